// File: doc/BRIEF.md
# Dual-Rail Reed-Muller Logic Cell

This block is a clocked model of a delay-insensitive logic cell. It is built for circuits written as sums of products that use only AND and XOR. Every data bit travels on two rails, so the code itself shows when a value is present. The cell takes three dual-rail operand words, `a`, `b` and `c`. It forms the product `b AND c`, and optionally folds that product into `a` with an XOR. It then passes the result through a one-word handshake register to the next stage. Chaining cells builds wider AND terms and longer XOR sums.

The operands are the stream into the cell. A word is present once every lane it needs carries a data code. The `req` line from the next stage acts as ready, and no word is taken while `req` is low. Once the cell accepts a word it raises `ack` and holds `z_dr`. It accepts nothing more until the sender has returned every operand to spacer and `req` has dropped. After that the output clears and `ack` falls. The `cfg_xor` pin decides which of the two internal select lines `req` drives. Those select lines stay low while `req` is low, including after reset. A complemented operand is made by swapping its two rails, and no inverter is involved.

Top module: `rmc_cell`

## Requirements
- R1: After reset, `z_dr` is all spacer, `ack` is 0 and `err` is 0.
- R2: Each lane is a rail pair [1:0]. The code 00 is spacer, 01 is logic 0 and 10 is logic 1. The code 11 is invalid, and `z_dr` never carries 11 in any lane.
- R3: With `cfg_xor`=1, `req` high and all lanes of `a`, `b` and `c` holding data, the cell captures `z = a XOR (b AND c)` per lane. `z_dr` and `ack` change together at the next clock edge.
- R4: With `cfg_xor`=0, the cell captures `z = b AND c`. It does not need `a`, which may stay at spacer.
- R5: While any lane of a needed operand is at spacer, `z_dr` stays spacer and `ack` stays 0. A rail stuck low on a data bit shows up as that case.
- R6: Valid operands presented while `req` is low are not taken. Nothing is captured until `req` is high, and `ack` rises only in the cycle after `req` was seen high.
- R7: While `ack` is high and the word has not been released, `z_dr` keeps the captured value whatever the operands do.
- R8: Once all operands are spacer and `req` is low, `z_dr` returns to spacer at the next edge and `ack` falls one edge later.
- R9: An 11 code on any lane of any operand sets `err` at the next edge. `err` then stays high until reset. That lane counts as missing data, so nothing is captured while the code persists.
- R10: Swapping the rails of an operand presents its complement, so `z = a XOR (NOT b AND c)` results with no other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xor | input | 1 | 1 selects the XOR-sum function, 0 selects the AND term |
| req | input | 1 | Ready from the next stage |
| a_dr | input | 2*W | Operand a, W rail pairs |
| b_dr | input | 2*W | Operand b, W rail pairs |
| c_dr | input | 2*W | Operand c, W rail pairs |
| z_dr | output | 2*W | Registered dual-rail result |
| ack | output | 1 | Acknowledge to the previous stage |
| err | output | 1 | Sticky invalid-code flag |

## Verification
The assertions check properties that hold on every cycle. The output never carries the invalid code, and `ack` rises only with a full data word after `req`. A captured word stays stable while it is held, `ack` falls only after the output has cleared, and `err` never drops. The arithmetic result in each mode can only be shown by the bench's scenarios. So can the wait on a missing lane, the refusal without `req`, the rail-swap complement and the blocking effect of an invalid lane.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef logic [1:0] dr_t;

  localparam dr_t DR_NULL = 2'b00;
  localparam dr_t DR_ZERO = 2'b01;
  localparam dr_t DR_ONE  = 2'b10;
  localparam dr_t DR_BAD  = 2'b11;

  function automatic logic dr_is_data(dr_t x);
    return (x == DR_ZERO) || (x == DR_ONE);
  endfunction

  // product waits for both operands; anything not data yields spacer
  function automatic dr_t dr_and(dr_t x, dr_t y);
    if (!dr_is_data(x) || !dr_is_data(y)) return DR_NULL;
    return ((x == DR_ONE) && (y == DR_ONE)) ? DR_ONE : DR_ZERO;
  endfunction

  function automatic dr_t dr_xor(dr_t x, dr_t y);
    if (!dr_is_data(x) || !dr_is_data(y)) return DR_NULL;
    return (x != y) ? DR_ONE : DR_ZERO;
  endfunction

  typedef enum logic [1:0] {HS_EMPTY, HS_FULL, HS_DRAIN} hs_state_t;
endpackage

// File: rtl/rmc_lane.sv
module rmc_lane
  import rmc_pkg::*;
(
  input  dr_t  a,
  input  dr_t  b,
  input  dr_t  c,
  input  logic sel_and,
  input  logic sel_xor,
  output dr_t  y,
  output logic y_ok,
  output logic bad,
  output logic idle
);
  dr_t prod;
  dr_t sum;

  always_comb begin
    prod = dr_and(b, c);
    sum  = dr_xor(a, prod);
    if (sel_xor)      y = sum;
    else if (sel_and) y = prod;
    else              y = DR_NULL;
    y_ok = dr_is_data(y);
    bad  = (a == DR_BAD) || (b == DR_BAD) || (c == DR_BAD);
    idle = (a == DR_NULL) && (b == DR_NULL) && (c == DR_NULL);
  end
endmodule

// File: rtl/rmc_hs_reg.sv
module rmc_hs_reg
  import rmc_pkg::*;
#(
  parameter int W = 4,
  localparam int DW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] d,
  input  logic          d_ok,
  input  logic          in_idle,
  output logic [DW-1:0] q,
  output logic          ack
);
  hs_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= HS_EMPTY;
      q   <= '0;
      ack <= 1'b0;
    end else begin
      unique case (st)
        HS_EMPTY: if (d_ok) begin
          q   <= d;
          ack <= 1'b1;
          st  <= HS_FULL;
        end
        HS_FULL: if (in_idle && !req) begin
          q  <= '0;
          st <= HS_DRAIN;
        end
        HS_DRAIN: begin
          ack <= 1'b0;
          st  <= HS_EMPTY;
        end
        default: st <= HS_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/rmc_cell.sv
module rmc_cell
  import rmc_pkg::*;
#(
  parameter int W = 4,
  localparam int DW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_xor,
  input  logic          req,
  input  logic [DW-1:0] a_dr,
  input  logic [DW-1:0] b_dr,
  input  logic [DW-1:0] c_dr,
  output logic [DW-1:0] z_dr,
  output logic          ack,
  output logic          err
);
  logic          sel_and, sel_xor;
  logic [DW-1:0] y_word;
  logic [W-1:0]  ok_v, bad_v, idle_v;

  assign sel_xor = req & cfg_xor;
  assign sel_and = req & ~cfg_xor;

  for (genvar i = 0; i < W; i++) begin : g_lane
    dr_t y_l;
    rmc_lane u_lane (
      .a(a_dr[2*i +: 2]), .b(b_dr[2*i +: 2]), .c(c_dr[2*i +: 2]),
      .sel_and(sel_and), .sel_xor(sel_xor),
      .y(y_l), .y_ok(ok_v[i]), .bad(bad_v[i]), .idle(idle_v[i])
    );
    assign y_word[2*i +: 2] = y_l;
  end

  rmc_hs_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .req(req),
    .d(y_word), .d_ok(&ok_v), .in_idle(&idle_v),
    .q(z_dr), .ack(ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      err <= 1'b0;
    else if (|bad_v) err <= 1'b1;
  end
endmodule

// File: rtl/rmc_cell_chk.sv
module rmc_cell_chk #(
  parameter int W = 4,
  localparam int DW = 2 * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [DW-1:0] z_dr,
  input logic          ack,
  input logic          err
);
  logic [W-1:0] z_data;
  for (genvar i = 0; i < W; i++) begin : g_l
    assign z_data[i] = (z_dr[2*i +: 2] == 2'b01) || (z_dr[2*i +: 2] == 2'b10);
    assert_no_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      z_dr[2*i +: 2] != 2'b11);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (z_dr == '0) && !ack && !err);

  assert_ack_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> &z_data);

  assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack) && ack && (z_dr != '0) && $past(z_dr != '0)) |-> $stable(z_dr));

  assert_ack_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> (z_dr == '0) && ($past(z_dr) == '0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);
endmodule

bind rmc_cell rmc_cell_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .z_dr(z_dr), .ack(ack), .err(err)
);

// File: tb/sim_rmc_cell.sv
`timescale 1ns/1ps
module sim_rmc_cell;
  localparam int W  = 4;
  localparam int DW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_xor = 1'b0;
  logic req = 1'b0;
  logic [DW-1:0] a_dr = '0, b_dr = '0, c_dr = '0;
  logic [DW-1:0] z_dr;
  logic ack, err;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  rmc_cell #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_xor(cfg_xor), .req(req),
    .a_dr(a_dr), .b_dr(b_dr), .c_dr(c_dr),
    .z_dr(z_dr), .ack(ack), .err(err)
  );

  // {mode, a, b, c, expected z}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 4'hA, 4'hC, 4'h6, 4'hE},
    {1'b1, 4'h0, 4'hF, 4'hF, 4'hF},
    {1'b1, 4'hF, 4'h0, 4'h9, 4'hF},
    {1'b0, 4'h5, 4'hC, 4'hA, 4'h8},
    {1'b0, 4'h0, 4'hF, 4'h3, 4'h3},
    {1'b1, 4'h3, 4'h5, 4'h7, 4'h6}
  };

  function automatic logic [DW-1:0] enc(logic [W-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [DW-1:0] swap(logic [DW-1:0] x);
    logic [DW-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = {x[2*i], x[2*i+1]};
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_n(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // release: operands to spacer, req low; z clears, then ack falls
  task automatic release_word(string tag);
    @(negedge clk);
    a_dr = '0; b_dr = '0; c_dr = '0; req = 1'b0;
    @(negedge clk);
    chk({tag, " z spacer"}, {24'd0, z_dr}, 32'd0);
    chk({tag, " ack held"}, {31'd0, ack}, 32'd1);
    @(negedge clk);
    chk({tag, " ack low"}, {31'd0, ack}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 z", {24'd0, z_dr}, 32'd0);
    chk("R1 ack", {31'd0, ack}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);

    // table walk: R3 (mode 1) and R4 (mode 0), each released per R8
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      cfg_xor = VEC[v][16];
      a_dr = VEC[v][16] ? enc(VEC[v][15:12]) : '0;
      b_dr = enc(VEC[v][11:8]);
      c_dr = enc(VEC[v][7:4]);
      req = 1'b1;
      @(negedge clk);
      chk(VEC[v][16] ? "R3 xor z" : "R4 and z", {24'd0, z_dr}, {24'd0, enc(VEC[v][3:0])});
      chk("R3 ack up", {31'd0, ack}, 32'd1);
      release_word("R8");
    end

    // R5: one lane of c missing; z must stay spacer
    @(negedge clk);
    cfg_xor = 1'b1; req = 1'b1;
    a_dr = enc(4'h1); b_dr = enc(4'hF); c_dr = enc(4'hF);
    c_dr[5:4] = 2'b00;
    idle_n(3);
    chk("R5 z wait", {24'd0, z_dr}, 32'd0);
    chk("R5 ack wait", {31'd0, ack}, 32'd0);
    c_dr = enc(4'hF);
    @(negedge clk);
    chk("R5 z after", {24'd0, z_dr}, {24'd0, enc(4'hE)});
    // R7: change operands while held
    b_dr = enc(4'h0); a_dr = enc(4'h5);
    idle_n(2);
    chk("R7 z held", {24'd0, z_dr}, {24'd0, enc(4'hE)});
    req = 1'b0;
    idle_n(2);
    chk("R7 z held no req", {24'd0, z_dr}, {24'd0, enc(4'hE)});
    release_word("R8 b");

    // R6: valid data without req
    @(negedge clk);
    cfg_xor = 1'b0;
    b_dr = enc(4'h6); c_dr = enc(4'hE);
    idle_n(3);
    chk("R6 z no req", {24'd0, z_dr}, 32'd0);
    chk("R6 ack no req", {31'd0, ack}, 32'd0);
    req = 1'b1;
    @(negedge clk);
    chk("R6 z after req", {24'd0, z_dr}, {24'd0, enc(4'h6)});
    release_word("R8 c");

    // R10: rail-swapped b presents NOT b
    @(negedge clk);
    cfg_xor = 1'b1; req = 1'b1;
    a_dr = enc(4'h0); b_dr = swap(enc(4'h3)); c_dr = enc(4'hF);
    @(negedge clk);
    chk("R10 z", {24'd0, z_dr}, {24'd0, enc(4'hC)});
    release_word("R8 d");

    // R9: invalid code blocks capture and sets sticky err
    @(negedge clk);
    cfg_xor = 1'b1; req = 1'b1;
    a_dr = enc(4'h0); b_dr = enc(4'h1); c_dr = enc(4'h1);
    a_dr[3:2] = 2'b11;
    @(negedge clk);
    chk("R9 err set", {31'd0, err}, 32'd1);
    chk("R9 no capture", {24'd0, z_dr}, 32'd0);
    a_dr = enc(4'h0);
    @(negedge clk);
    chk("R9 err sticky", {31'd0, err}, 32'd1);
    chk("R9 capture after fix", {24'd0, z_dr}, {24'd0, enc(4'h1)});
    release_word("R8 e");

    // R1 again: reset clears err
    @(negedge clk);
    rst_n = 1'b0;
    idle_n(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err cleared", {31'd0, err}, 32'd0);
    chk("R1 z cleared", {24'd0, z_dr}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule